// File: doc/BRIEF.md
# Pulse-Rate Generator with Step/Direction Mode

The block turns an unsigned rate command into a train of one-clock pulses, one train per channel. The pulse count is proportional to the command, and the pulses are spread as evenly as the clock grid allows. The output therefore carries little low-frequency ripple, and a plain RC network outside the chip can turn it into a smooth analog level. Each channel holds a phase accumulator `CMD_W` bits wide. On every enabled clock it adds the command magnitude, and the carry out of its top bit becomes the pulse. A command N therefore yields exactly N pulses in every 2^CMD_W enabled clocks.

Software writes each channel's command into a holding register. A shared update strobe then moves all the held commands into the accumulators at once, so the servo update rate is set entirely by when software raises the strobe. When step mode is selected, the same engine drives a motor drive. The command's top bit is then a two's-complement sign, the magnitude sets the step rate, and a direction output follows the sign. A direction change is always in place at least one clock before the next step.

Top module: `pfm_gen`

## Requirements
- R1: While `rst_n` is low, every `pulse_out` and `dir_out` bit is 0, and the accumulators restart from zero.
- R2: A committed command N on a channel gives exactly N pulses, each one clock wide, in every 2^CMD_W consecutive enabled clocks.
- R3: A committed command of 0 gives no pulses.
- R4: Pulses are spread evenly. The largest gap between consecutive pulses is ceil(2^CMD_W / N) clocks, so for N = 3 at 4-bit width the gaps are 5 and 6, and never one run of adjacent pulses.
- R5: Writing a channel's holding register with `cmd_wr` does not change that channel's output until `cmd_update` is raised.
- R6: `cmd_update` commits every holding register at once, and the new rate applies from the next clock. When `cmd_wr` and `cmd_update` are high in the same cycle, the value written in that cycle is the one committed.
- R7: With `step_mode` = 1, command bit CMD_W-1 is the sign (1 = negative) of a two's-complement value. The pulse rate follows its magnitude, and `dir_out` equals the sign bit.
- R8: `dir_out` never changes on the clock edge where a step pulse rises. After a sign change it settles at least one clock before the first step in the new direction.
- R9: While `clk_en` is low, the accumulators hold their value and no pulses are produced.
- R10: With `step_mode` = 0, `dir_out` stays 0 whatever the command's top bit is, and the full CMD_W-bit value sets the rate.
- R11: Channels are independent. Each channel's rate depends only on its own committed command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Accumulator advance enable; sets the base rate |
| step_mode | input | 1 | 0 = unsigned rate output, 1 = signed step/direction |
| cmd_wr | input | NUM_CH | Per-channel write strobe for the holding register |
| cmd_data | input | NUM_CH*CMD_W | Per-channel command; channel i at bits [i*CMD_W +: CMD_W] |
| cmd_update | input | 1 | Commits all holding registers to the generators |
| pulse_out | output | NUM_CH | One-clock pulse train per channel |
| dir_out | output | NUM_CH | Direction per channel (step mode only) |

## Verification
Two functions can land in the same cycle. The first pair is a command write and the update strobe: the bench raises `cmd_wr` together with `cmd_update` and expects the rate of the value written in that same cycle, not the older held value. The second pair is a direction change and a step. The bench commits a sign reversal while both channels are stepping at high rates, and checks on every sampled pulse that `dir_out` matches its value from the previous cycle. Pulse count and largest gap are judged over a whole window rather than by exact phase.

// File: rtl/pfm_gen_pkg.sv
package pfm_gen_pkg;
   typedef enum logic {
      DRV_RATE = 1'b0,
      DRV_STEP = 1'b1
   } drive_mode_e;

   localparam int unsigned MIN_CMD_W = 2;
endpackage

// File: rtl/pfm_cmd_latch.sv
module pfm_cmd_latch #(
   parameter int unsigned CMD_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CMD_W-1:0] wr_data,
   input  logic             update,
   output logic [CMD_W-1:0] active_q,
   output logic [CMD_W-1:0] active_d
);
   logic [CMD_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hold_q <= '0;
      else if (wr_en) hold_q <= wr_data;
   end

   // a write in the update cycle is forwarded straight into the commit
   always_comb begin
      active_d = active_q;
      if (update) active_d = wr_en ? wr_data : hold_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= '0;
      else        active_q <= active_d;
   end

   // R5
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !update |=> $stable(active_q));
endmodule

// File: rtl/pfm_accum.sv
module pfm_accum #(
   parameter int unsigned ACC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [ACC_W-1:0] mag,
   output logic             carry_nxt,
   output logic             pulse_q
);
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   sum;

   always_comb begin
      sum       = {1'b0, acc_q} + {1'b0, mag};
      carry_nxt = en & sum[ACC_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         if (en) acc_q <= sum[ACC_W-1:0];
         pulse_q <= carry_nxt;
      end
   end

   // R9
   acc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(acc_q));
   // R3
   zero_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mag == '0) |=> !pulse_q);
endmodule

// File: rtl/pfm_dir_ctl.sv
module pfm_dir_ctl
   import pfm_gen_pkg::*;
#(
   parameter int unsigned CMD_W     = 16,
   parameter bit          TWOS_SIGN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  drive_mode_e      mode,
   input  logic [CMD_W-1:0] active_q,
   input  logic [CMD_W-1:0] active_d,
   input  logic             fire_nxt,
   output logic [CMD_W-1:0] mag,
   output logic             dir_q
);
   localparam int unsigned TOP = CMD_W - 1;

   logic neg_now;
   logic dir_target;

   assign neg_now    = (mode == DRV_STEP) & active_q[TOP];
   assign dir_target = (mode == DRV_STEP) & active_d[TOP];

   generate
      if (TWOS_SIGN) begin : g_twos
         always_comb mag = neg_now ? (~active_q + CMD_W'(1)) : active_q;
      end else begin : g_signmag
         always_comb mag = neg_now ? {1'b0, active_q[TOP-1:0]} : active_q;
      end
   endgenerate

   // hold direction on an edge that launches a step; the step after a
   // sign change can never follow the last old step directly, so the
   // deferred update always lands between the two
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dir_q <= 1'b0;
      else if (!fire_nxt) dir_q <= dir_target;
   end

   // R10
   rate_dir_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == DRV_RATE && !fire_nxt) |=> !dir_q);
endmodule

// File: rtl/pfm_gen.sv
module pfm_gen
   import pfm_gen_pkg::*;
#(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned CMD_W     = 16,
   parameter bit          TWOS_SIGN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en,
   input  logic                    step_mode,
   input  logic [NUM_CH-1:0]       cmd_wr,
   input  logic [NUM_CH*CMD_W-1:0] cmd_data,
   input  logic                    cmd_update,
   output logic [NUM_CH-1:0]       pulse_out,
   output logic [NUM_CH-1:0]       dir_out
);
   localparam int unsigned BUS_W = NUM_CH * CMD_W;

   generate
      if (CMD_W < MIN_CMD_W) begin : g_bad_width
         $error("pfm_gen: CMD_W must be at least %0d", MIN_CMD_W);
      end
      if (NUM_CH < 1) begin : g_bad_count
         $error("pfm_gen: NUM_CH must be at least 1");
      end
      if (BUS_W != NUM_CH * CMD_W) begin : g_bad_bus
         $error("pfm_gen: command bus width mismatch");
      end
   endgenerate

   drive_mode_e mode;
   assign mode = step_mode ? DRV_STEP : DRV_RATE;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic [CMD_W-1:0] active_q;
         logic [CMD_W-1:0] active_d;
         logic [CMD_W-1:0] mag;
         logic             fire_nxt;

         pfm_cmd_latch #(.CMD_W(CMD_W)) u_latch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cmd_wr[ch]),
            .wr_data  (cmd_data[ch*CMD_W +: CMD_W]),
            .update   (cmd_update),
            .active_q (active_q),
            .active_d (active_d)
         );

         pfm_dir_ctl #(.CMD_W(CMD_W), .TWOS_SIGN(TWOS_SIGN)) u_dir (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode),
            .active_q (active_q),
            .active_d (active_d),
            .fire_nxt (fire_nxt),
            .mag      (mag),
            .dir_q    (dir_out[ch])
         );

         pfm_accum #(.ACC_W(CMD_W)) u_acc (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (clk_en),
            .mag       (mag),
            .carry_nxt (fire_nxt),
            .pulse_q   (pulse_out[ch])
         );

         // R8
         dir_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_out[ch] |-> $stable(dir_out[ch]));
      end
   endgenerate

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (pulse_out == '0 && dir_out == '0));
endmodule

// File: tb/pfm_gen_bench.sv
module pfm_gen_bench;
   localparam int NCH = 2;
   localparam int CW  = 4;
   localparam int WIN = 1 << CW;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              clk_en;
   logic              step_mode;
   logic [NCH-1:0]    cmd_wr;
   logic [NCH*CW-1:0] cmd_data;
   logic              cmd_update;
   logic [NCH-1:0]    pulse_out;
   logic [NCH-1:0]    dir_out;

   always #10 clk = ~clk;

   pfm_gen #(.NUM_CH(NCH), .CMD_W(CW), .TWOS_SIGN(1'b1)) u_pfm_gen (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .step_mode(step_mode),
      .cmd_wr(cmd_wr), .cmd_data(cmd_data), .cmd_update(cmd_update),
      .pulse_out(pulse_out), .dir_out(dir_out)
   );

   typedef struct {
      string tag;
      int    cnt [NCH];
      int    gap [NCH];
      int    dir [NCH];
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   fails  = 0;
   int   dir_viol = 0;
   bit   mon_req = 1'b0;
   bit   done = 1'b0;

   task automatic chk(string req, int act, int expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int max_gap(int n);
      return (n == 0) ? 0 : (WIN + n - 1) / n;
   endfunction

   // expected window for a channel: rate n, direction d
   task automatic push_exp(string tag, int n0, int d0, int n1, int d1);
      exp_t e;
      e.tag = tag;
      e.cnt[0] = 2 * n0; e.gap[0] = max_gap(n0); e.dir[0] = d0;
      e.cnt[1] = 2 * n1; e.gap[1] = max_gap(n1); e.dir[1] = d1;
      exp_q.push_back(e);
      mon_req = 1'b1;
      wait (mon_req == 1'b0);
   endtask

   task automatic write_cmd(int ch, logic [CW-1:0] v, bit upd);
      @(negedge clk);
      cmd_wr[ch] = 1'b1;
      cmd_data[ch*CW +: CW] = v;
      cmd_update = upd;
      @(negedge clk);
      cmd_wr = '0;
      cmd_update = 1'b0;
   endtask

   task automatic commit();
      @(negedge clk);
      cmd_update = 1'b1;
      @(negedge clk);
      cmd_update = 1'b0;
   endtask

   // monitor: measures two full windows and compares with the queue head
   initial begin
      forever begin
         wait (mon_req == 1'b1);
         begin
            int cnt [NCH];
            int gap [NCH];
            int last [NCH];
            exp_t e;
            for (int c = 0; c < NCH; c++) begin
               cnt[c] = 0; gap[c] = 0; last[c] = -1;
            end
            repeat (3) @(negedge clk);
            for (int t = 0; t < 2 * WIN; t++) begin
               @(negedge clk);
               for (int c = 0; c < NCH; c++) begin
                  if (pulse_out[c]) begin
                     cnt[c]++;
                     if (last[c] >= 0 && (t - last[c]) > gap[c]) gap[c] = t - last[c];
                     last[c] = t;
                  end
               end
            end
            e = exp_q.pop_front();
            for (int c = 0; c < NCH; c++) begin
               chk($sformatf("%s ch%0d count", e.tag, c), cnt[c], e.cnt[c]);
               chk($sformatf("%s ch%0d max gap", e.tag, c), gap[c], e.gap[c]);
               chk($sformatf("%s ch%0d dir", e.tag, c), int'(dir_out[c]), e.dir[c]);
            end
         end
         mon_req = 1'b0;
      end
   end

   // R8: direction must match the previous sample whenever a step is high
   logic [NCH-1:0] prev_dir = '0;
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         for (int c = 0; c < NCH; c++)
            if (pulse_out[c] && dir_out[c] != prev_dir[c]) dir_viol++;
      end
      prev_dir <= dir_out;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; clk_en = 1'b1; step_mode = 1'b0;
      cmd_wr = '0; cmd_data = '0; cmd_update = 1'b0;
      repeat (2) @(negedge clk);
      // R1
      chk("R1 pulse_out in reset", int'(pulse_out), 0);
      chk("R1 dir_out in reset", int'(dir_out), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R3: nothing committed yet
      push_exp("R3 zero", 0, 0, 0, 0);

      // R2 R4 R11: distinct rates per channel
      write_cmd(0, 4'd1, 1'b0);
      write_cmd(1, 4'd2, 1'b0);
      commit();
      push_exp("R2 R11 rates 1/2", 1, 0, 2, 0);
      write_cmd(0, 4'd3, 1'b0);
      write_cmd(1, 4'd4, 1'b0);
      commit();
      push_exp("R4 rates 3/4", 3, 0, 4, 0);

      // R5: write without commit leaves the old rate
      write_cmd(0, 4'd7, 1'b0);
      push_exp("R5 held", 3, 0, 4, 0);
      commit();
      push_exp("R6 commit", 7, 0, 4, 0);

      // R6: write and commit in one cycle
      write_cmd(1, 4'd15, 1'b1);
      push_exp("R6 same-cycle", 7, 0, 15, 0);

      // R10: top bit set in rate mode is just a large rate
      write_cmd(0, 4'd12, 1'b1);
      push_exp("R10 rate mode", 12, 0, 15, 0);

      // R9: clock enable low stops everything
      @(negedge clk); clk_en = 1'b0;
      push_exp("R9 disabled", 0, 0, 0, 0);
      @(negedge clk); clk_en = 1'b1;

      // R7: signed step mode (0xD = -3, 0x5 = +5)
      @(negedge clk); step_mode = 1'b1;
      write_cmd(0, 4'hD, 1'b0);
      write_cmd(1, 4'h5, 1'b0);
      commit();
      push_exp("R7 step", 3, 1, 5, 0);

      // R8: reverse both while stepping fast (0x8 = -8)
      write_cmd(0, 4'h3, 1'b0);
      write_cmd(1, 4'h8, 1'b0);
      commit();
      push_exp("R8 reversal", 3, 0, 8, 1);
      write_cmd(0, 4'h9, 1'b0);
      write_cmd(1, 4'h7, 1'b0);
      commit();
      push_exp("R8 reversal back", 7, 1, 7, 0);
      chk("R8 dir changed on a step edge", dir_viol, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule